// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block joins two parallel data buses, called A and B, through a non-inverting transceiver. It is built from independent lanes, two lanes of 8 bits each by default. Each bidirectional bus pin is modelled as three separate signals: an input, an output and an output enable. Because of this, the surrounding logic can resolve the pin, and no tri-state net is needed inside the block.

Every lane holds two storage registers, one for the A side and one for the B side. The driven side of a lane can show either the live value from the opposite side or the value held in that side's register. Each register loads on the rising edge of its own capture strobe. The strobes are sampled by the block clock. A register loads whether or not the lane is driving. Because of this, data can be captured while the lane is isolated and replayed later.

Per lane, the output-enable input is active low, and a direction input picks the side that drives. When the enable is high, neither side drives.

Top module: `regbus_xcvr`

## Requirements
- R1: Lane `l` covers bits `[l*LANE_W +: LANE_W]` of every data and enable vector. Lane `l` is controlled only by bit `l` of `oe_n`, `dir`, `cap_ab`, `cap_ba`, `sel_ab` and `sel_ba`.
- R2: At a clock edge where `cap_ab[l]` is sampled 1 and was sampled 0 at the previous edge, the lane's A register loads the `a_in` lane value present at that edge. `cap_ba[l]` and `b_in` load the B register in the same way.
- R3: A capture works the same way while the lane is isolated (`oe_n[l]`=1), and the captured value can later be replayed onto the opposite bus.
- R4: A register keeps its value at every edge without a new strobe rise. A strobe held at 1 over several edges loads only once.
- R5: While `oe_n[l]`=1, the lane's `a_en` and `b_en` bits are 0. An undriven side always shows 0 on its `*_out` bits.
- R6: While `oe_n[l]`=0 and `dir[l]`=0, the lane's `a_en` bits are all 1 and its `b_en` bits are 0. `a_out` equals the B register when `sel_ba[l]`=1, and the `b_in` lane value when `sel_ba[l]`=0, with no inversion.
- R7: While `oe_n[l]`=0 and `dir[l]`=1, the lane's `b_en` bits are all 1 and its `a_en` bits are 0. `b_out` equals the A register when `sel_ab[l]`=1, and the `a_in` lane value when `sel_ab[l]`=0, with no inversion.
- R8: While `rst`=1, all enables and outputs are 0. At a clock edge with `rst`=1, both registers of every lane clear to 0, and no capture takes place.
- R9: No bit of `a_en` and `b_en` is 1 at the same time.
- R10: The live path is combinational. A change on `b_in` (or `a_in`) shows on `a_out` (or `b_out`) without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples strobes and loads registers |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | LANES | Per-lane output enable, active low |
| dir | input | LANES | Per-lane direction: 0 drives A, 1 drives B |
| cap_ab | input | LANES | Per-lane A-register capture strobe |
| cap_ba | input | LANES | Per-lane B-register capture strobe |
| sel_ab | input | LANES | Source for B output: 0 live A, 1 stored A |
| sel_ba | input | LANES | Source for A output: 0 live B, 1 stored B |
| a_in | input | LANES*LANE_W | Value seen on the A bus pins |
| a_out | output | LANES*LANE_W | Value driven on the A bus pins |
| a_en | output | LANES*LANE_W | Per-bit drive enable for the A bus |
| b_in | input | LANES*LANE_W | Value seen on the B bus pins |
| b_out | output | LANES*LANE_W | Value driven on the B bus pins |
| b_en | output | LANES*LANE_W | Per-bit drive enable for the B bus |

## Verification
The bench uses the default parameters, `LANES`=2 and `LANE_W`=8. With two lanes, one lane can be isolated and capturing while the other drives in the opposite direction, which exposes any leak of control or data between lanes. With a lane width of 8, random data runs through every bit pattern a lane can carry, so an inverted, swapped or stuck bit on either live or stored path is caught. Directed sequences cover capture during isolation and later replay, a strobe held high across edges, and a reset in mid-run that clears stored data.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;

  typedef enum logic [1:0] {
    LANE_ISOLATE = 2'd0,
    LANE_DRIVE_A = 2'd1,
    LANE_DRIVE_B = 2'd2
  } lane_mode_e;

  // Lane drive mode from reset, active-low enable and direction.
  function automatic lane_mode_e decode_mode(input logic rst, input logic oe_n, input logic dir);
    if (rst || oe_n) return LANE_ISOLATE;
    else if (dir)    return LANE_DRIVE_B;
    else             return LANE_DRIVE_A;
  endfunction

  // A strobe rise: high now, low at the previous sample.
  function automatic logic strobe_rose(input logic now_v, input logic before_v);
    return now_v & ~before_v;
  endfunction

endpackage

// File: rtl/regbus_xcvr_rise.sv
module regbus_xcvr_rise
  import regbus_xcvr_pkg::*;
#(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] strobe_i,
  output logic [N-1:0] rise_o
);

  logic [N-1:0] prev_q;

  // Follows the strobe through reset too, so a level held over reset
  // release is not taken as a fresh rise.
  always_ff @(posedge clk) begin
    prev_q <= strobe_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rise_o[i] = ~rst & strobe_rose(strobe_i[i], prev_q[i]);
  end

endmodule

// File: rtl/regbus_xcvr_store.sv
module regbus_xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (rst)         q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

endmodule

// File: rtl/regbus_xcvr_lane.sv
module regbus_xcvr_lane
  import regbus_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  lane_mode_e   mode_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic         cap_a_i,
  input  logic         cap_b_i,
  input  logic [W-1:0] a_in_i,
  input  logic [W-1:0] b_in_i,
  output logic [W-1:0] a_out_o,
  output logic [W-1:0] a_en_o,
  output logic [W-1:0] b_out_o,
  output logic [W-1:0] b_en_o,
  output logic [W-1:0] a_q_o,
  output logic [W-1:0] b_q_o
);

  logic         a_drive;
  logic         b_drive;
  logic [W-1:0] a_src;
  logic [W-1:0] b_src;

  regbus_xcvr_store #(.W(W)) a_store_i (
    .clk(clk), .rst(rst), .load_i(cap_a_i), .d_i(a_in_i), .q_o(a_q_o)
  );

  regbus_xcvr_store #(.W(W)) b_store_i (
    .clk(clk), .rst(rst), .load_i(cap_b_i), .d_i(b_in_i), .q_o(b_q_o)
  );

  assign a_drive = (mode_i == LANE_DRIVE_A);
  assign b_drive = (mode_i == LANE_DRIVE_B);

  assign a_src = sel_ba_i ? b_q_o : b_in_i;
  assign b_src = sel_ab_i ? a_q_o : a_in_i;

  assign a_out_o = a_drive ? a_src : '0;
  assign b_out_o = b_drive ? b_src : '0;
  assign a_en_o  = {W{a_drive}};
  assign b_en_o  = {W{b_drive}};

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_xcvr_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LANES-1:0]         oe_n,
  input  logic [LANES-1:0]         dir,
  input  logic [LANES-1:0]         cap_ab,
  input  logic [LANES-1:0]         cap_ba,
  input  logic [LANES-1:0]         sel_ab,
  input  logic [LANES-1:0]         sel_ba,
  input  logic [LANES*LANE_W-1:0]  a_in,
  output logic [LANES*LANE_W-1:0]  a_out,
  output logic [LANES*LANE_W-1:0]  a_en,
  input  logic [LANES*LANE_W-1:0]  b_in,
  output logic [LANES*LANE_W-1:0]  b_out,
  output logic [LANES*LANE_W-1:0]  b_en
);

  localparam int W = LANES * LANE_W;

  // Named internal events for the checker.
  logic [LANES-1:0] a_cap_evt;
  logic [LANES-1:0] b_cap_evt;
  logic [W-1:0]     a_store;
  logic [W-1:0]     b_store;

  regbus_xcvr_rise #(.N(LANES)) ab_rise_i (
    .clk(clk), .rst(rst), .strobe_i(cap_ab), .rise_o(a_cap_evt)
  );

  regbus_xcvr_rise #(.N(LANES)) ba_rise_i (
    .clk(clk), .rst(rst), .strobe_i(cap_ba), .rise_o(b_cap_evt)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_mode_e mode;
    assign mode = decode_mode(rst, oe_n[g], dir[g]);

    regbus_xcvr_lane #(.W(LANE_W)) lane_i (
      .clk     (clk),
      .rst     (rst),
      .mode_i  (mode),
      .sel_ab_i(sel_ab[g]),
      .sel_ba_i(sel_ba[g]),
      .cap_a_i (a_cap_evt[g]),
      .cap_b_i (b_cap_evt[g]),
      .a_in_i  (a_in[g*LANE_W +: LANE_W]),
      .b_in_i  (b_in[g*LANE_W +: LANE_W]),
      .a_out_o (a_out[g*LANE_W +: LANE_W]),
      .a_en_o  (a_en[g*LANE_W +: LANE_W]),
      .b_out_o (b_out[g*LANE_W +: LANE_W]),
      .b_en_o  (b_en[g*LANE_W +: LANE_W]),
      .a_q_o   (a_store[g*LANE_W +: LANE_W]),
      .b_q_o   (b_store[g*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [LANES-1:0]        oe_n,
  input logic [LANES-1:0]        dir,
  input logic [LANES-1:0]        cap_ab,
  input logic [LANES-1:0]        cap_ba,
  input logic [LANES-1:0]        sel_ab,
  input logic [LANES-1:0]        sel_ba,
  input logic [LANES*LANE_W-1:0] a_in,
  input logic [LANES*LANE_W-1:0] a_out,
  input logic [LANES*LANE_W-1:0] a_en,
  input logic [LANES*LANE_W-1:0] b_in,
  input logic [LANES*LANE_W-1:0] b_out,
  input logic [LANES*LANE_W-1:0] b_en,
  input logic [LANES-1:0]        a_cap_evt,
  input logic [LANES-1:0]        b_cap_evt,
  input logic [LANES*LANE_W-1:0] a_store,
  input logic [LANES*LANE_W-1:0] b_store
);

  localparam logic [LANE_W-1:0] ONES = {LANE_W{1'b1}};

  // R9
  en_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (a_en & b_en) == '0);

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    rst |-> (a_en == '0 && b_en == '0 && a_out == '0 && b_out == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // R2
    a_rise_evt_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(cap_ab[g]) |-> a_cap_evt[g]);
    // R2
    b_rise_evt_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(cap_ba[g]) |-> b_cap_evt[g]);
    // R2
    a_load_chk: assert property (@(posedge clk) disable iff (rst)
      a_cap_evt[g] |=> a_store[g*LANE_W +: LANE_W] == $past(a_in[g*LANE_W +: LANE_W]));
    // R2
    b_load_chk: assert property (@(posedge clk) disable iff (rst)
      b_cap_evt[g] |=> b_store[g*LANE_W +: LANE_W] == $past(b_in[g*LANE_W +: LANE_W]));
    // R4
    a_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !a_cap_evt[g] |=> $stable(a_store[g*LANE_W +: LANE_W]));
    // R4
    b_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !b_cap_evt[g] |=> $stable(b_store[g*LANE_W +: LANE_W]));
    // R5
    isolate_chk: assert property (@(posedge clk) disable iff (rst)
      oe_n[g] |-> (a_en[g*LANE_W +: LANE_W] == '0 && b_en[g*LANE_W +: LANE_W] == '0));
    // R6
    drive_a_stored_chk: assert property (@(posedge clk) disable iff (rst)
      (!oe_n[g] && !dir[g] && sel_ba[g]) |->
        (a_en[g*LANE_W +: LANE_W] == ONES && a_out[g*LANE_W +: LANE_W] == b_store[g*LANE_W +: LANE_W]));
    // R6
    drive_a_live_chk: assert property (@(posedge clk) disable iff (rst)
      (!oe_n[g] && !dir[g] && !sel_ba[g]) |-> a_out[g*LANE_W +: LANE_W] == b_in[g*LANE_W +: LANE_W]);
    // R7
    drive_b_stored_chk: assert property (@(posedge clk) disable iff (rst)
      (!oe_n[g] && dir[g] && sel_ab[g]) |->
        (b_en[g*LANE_W +: LANE_W] == ONES && b_out[g*LANE_W +: LANE_W] == a_store[g*LANE_W +: LANE_W]));
    // R7
    drive_b_live_chk: assert property (@(posedge clk) disable iff (rst)
      (!oe_n[g] && dir[g] && !sel_ab[g]) |-> b_out[g*LANE_W +: LANE_W] == a_in[g*LANE_W +: LANE_W]);
  end

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W)) chk_i (.*);

// File: tb/regbus_xcvr_tb_top.sv
module regbus_xcvr_tb_top;

  localparam int PERIOD = 10;
  localparam int LN = 2;
  localparam int LW = 8;
  localparam int W  = LN * LW;

  logic          clk = 1'b0;
  logic          rst;
  logic [LN-1:0] oe_n, dir, cap_ab, cap_ba, sel_ab, sel_ba;
  logic [W-1:0]  a_in, b_in;
  logic [W-1:0]  a_out, a_en, b_out, b_en;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  // Behavioural reference state.
  logic [LW-1:0] ma [LN];
  logic [LW-1:0] mb [LN];
  bit            pab [LN];
  bit            pba [LN];

  always #(PERIOD/2) clk = ~clk;

  regbus_xcvr #(.LANES(LN), .LANE_W(LW)) dut_i (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_en(a_en),
    .b_in(b_in), .b_out(b_out), .b_en(b_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    for (int l = 0; l < LN; l++) begin ma[l] = '0; mb[l] = '0; end
  end

  // Reference model update at each active edge.
  always @(posedge clk) begin
    for (int l = 0; l < LN; l++) begin
      if (rst) begin
        ma[l] = '0;
        mb[l] = '0;
      end else begin
        if (cap_ab[l] && !pab[l]) ma[l] = a_in[l*LW +: LW];
        if (cap_ba[l] && !pba[l]) mb[l] = b_in[l*LW +: LW];
      end
      pab[l] = cap_ab[l];
      pba[l] = cap_ba[l];
    end
  end

  // Cycle compare, a quarter period after inputs change.
  always @(negedge clk) begin
    #(PERIOD/4);
    for (int l = 0; l < LN; l++) begin
      logic          ea, eb;
      logic [LW-1:0] oa, ob;
      string         tag;
      ea = !rst && !oe_n[l] && !dir[l];
      eb = !rst && !oe_n[l] &&  dir[l];
      oa = ea ? (sel_ba[l] ? mb[l] : b_in[l*LW +: LW]) : '0;
      ob = eb ? (sel_ab[l] ? ma[l] : a_in[l*LW +: LW]) : '0;
      if (rst)          tag = "R8";
      else if (oe_n[l]) tag = "R5";
      else if (!dir[l]) tag = "R6";
      else              tag = "R7";
      tag = $sformatf("%s lane %0d (R1) a_en", tag, l);
      check(tag, 32'(a_en[l*LW +: LW]), 32'({LW{ea}}));
      check({tag, " a_out"}, 32'(a_out[l*LW +: LW]), 32'(oa));
      check({tag, " b_en"},  32'(b_en[l*LW +: LW]),  32'({LW{eb}}));
      check({tag, " b_out"}, 32'(b_out[l*LW +: LW]), 32'(ob));
    end
    check("R9 enable overlap", 32'(a_en & b_en), 32'd0);
  end

  // Watchdog.
  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  task automatic settle();
    #(PERIOD/4 + 1);
  endtask

  initial begin
    rst = 1'b1; oe_n = 2'b00; dir = 2'b01;
    cap_ab = '0; cap_ba = '0; sel_ab = '0; sel_ba = '0;
    a_in = 16'hFFFF; b_in = 16'hAAAA;
    repeat (3) @(negedge clk);
    settle();
    // R8: quiet during reset even with lanes enabled
    check("R8 reset a_en", 32'(a_en), 32'd0);
    check("R8 reset b_out", 32'(b_out), 32'd0);

    @(negedge clk);
    rst = 1'b0; oe_n = 2'b11; a_in[7:0] = 8'h5A; cap_ab[0] = 1'b1;
    @(negedge clk);
    cap_ab[0] = 1'b0; a_in[7:0] = 8'h00;
    settle();
    check("R5 isolated lane0 b_en", 32'(b_en[7:0]), 32'd0);
    @(negedge clk);
    oe_n[0] = 1'b0; dir[0] = 1'b1; sel_ab[0] = 1'b1;
    settle();
    check("R3 lane0 replay of isolated capture", 32'(b_out[7:0]), 32'h5A);
    check("R7 lane0 b_en", 32'(b_en[7:0]), 32'hFF);

    b_in[15:8] = 8'hC3; cap_ba[1] = 1'b1;
    @(negedge clk);
    cap_ba[1] = 1'b0; b_in[15:8] = 8'h11;
    @(negedge clk);
    oe_n[1] = 1'b0; dir[1] = 1'b0; sel_ba[1] = 1'b1;
    settle();
    check("R3 lane1 replay of isolated capture", 32'(a_out[15:8]), 32'hC3);
    check("R1 lane0 unaffected by lane1", 32'(b_out[7:0]), 32'h5A);

    @(negedge clk);
    sel_ba[1] = 1'b0; b_in[15:8] = 8'h7E;
    settle();
    check("R10 live B to A", 32'(a_out[15:8]), 32'h7E);
    b_in[15:8] = 8'h81;
    #1;
    check("R10 live B to A without clock", 32'(a_out[15:8]), 32'h81);

    @(negedge clk);
    cap_ab[0] = 1'b1; a_in[7:0] = 8'h33;
    @(negedge clk);
    a_in[7:0] = 8'h44;
    @(negedge clk);
    settle();
    check("R4 held strobe loads once", 32'(b_out[7:0]), 32'h33);
    @(negedge clk);
    cap_ab[0] = 1'b0;
    @(negedge clk);
    cap_ab[0] = 1'b1;
    @(negedge clk);
    cap_ab[0] = 1'b0;
    settle();
    check("R2 new rise loads", 32'(b_out[7:0]), 32'h44);

    @(negedge clk);
    rst = 1'b1;
    settle();
    check("R8 mid-run reset quiet", 32'(b_en), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    settle();
    check("R8 stored A cleared", 32'(b_out[7:0]), 32'h00);

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      oe_n   = 2'($urandom);
      dir    = 2'($urandom);
      cap_ab = 2'($urandom);
      cap_ba = 2'($urandom);
      sel_ab = 2'($urandom);
      sel_ba = 2'($urandom);
      a_in   = 16'($urandom);
      b_in   = 16'($urandom);
      rst    = ($urandom % 97) == 0;
    end
    @(negedge clk);
    settle();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule